// File: doc/BRIEF.md
# Cache Way Sizing Controller

This block sets how many ways of a 16-way shared cache are switched on. The enabled ways are always the lowest-numbered ones, so the controller keeps a single count of enabled ways and derives the per-way enable mask from it. When a shrink request arrives, the controller latches a step size. It then takes the cache down in steps. In each step it asks for the top ways to be flushed, waits for the flush acknowledge, and only then switches those ways off. This repeats until no way is left on, at which point the cache is reported empty.

A wake event that arrives during shrinking lets the current step finish and then stops. The partly enabled mask is left in place. Regrowth has a guard: the count of enabled ways may only rise once the deep-sleep indicator has stayed low for a programmable number of consecutive cycles. From then on, ways come back one at a time, with a programmable gap between them, until all 16 are on. If the deep-sleep indicator rises again, the residency count returns to zero and regrowth stops until the count is met again.

Top module: `way_sizer`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), all 16 ways are enabled (way_en = 16'hFFFF), flush_req is zero and empty is low.
- R2: Enable encoding: way_en bit i high means way i is enabled, and enabled ways are always ways 0 to count-1. A shrink request sampled while at least one way is enabled starts a step in the next cycle. In that step, flush_req marks the top n ways that are still enabled. Those ways are disabled in the cycle after flush_done is sampled, and the next step's flush_req follows in that same cycle.
- R3: The step size n is taken from step_ways when shrinking starts and is held until shrinking ends. A value of 0 is used as 1, a value above 16 is used as 16, and the last step is cut down to the ways that remain.
- R4: empty is high exactly when no way is enabled, and it never rises while a step is waiting for flush_done.
- R5: While idle, no way is re-enabled until deep_state has been low for resid_cycles consecutive clock edges. A clock edge with deep_state high, or any shrink activity, sets that count back to zero.
- R6: Once the residency count is met, one way is added every grow_ivl cycles (a value of 0 is used as 1) until 16 ways are enabled. With resid_cycles = R and grow_ivl = I, the first way appears after edge R+I, counted from the first edge with deep_state low.
- R7: A wake pulse seen while shrinking lets the current step complete at its flush_done and then ends shrinking. The reduced mask is kept, and flush_req returns to zero.
- R8: A shrink request with no way enabled, and a flush_done with no step in progress, leave way_en, flush_req and empty unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shrink_req | input | 1 | Start shrinking the cache |
| wake | input | 1 | Wake event; stops shrinking after the current step |
| deep_state | input | 1 | High while the package is in a deep sleep state |
| step_ways | input | 5 | Ways removed per step, sampled when shrinking starts |
| resid_cycles | input | 16 | Cycles out of deep sleep required before regrowth |
| grow_ivl | input | 8 | Cycles between successive re-enabled ways |
| flush_done | input | 1 | Acknowledge that the current flush has finished |
| way_en | output | 16 | Enabled-ways mask |
| flush_req | output | 16 | Ways to flush in the current step |
| empty | output | 1 | No way enabled |

## Verification
Every output comes from registers, so a stimulus sampled at one rising edge shows up at the outputs after that edge:
- flush_req, one cycle after shrink_req;
- the reduced mask and the next step's flush_req, one cycle after flush_done;
- the first regrown way, R+I edges after deep_state falls.

The bench drives inputs on falling edges. A behavioural model steps on each rising edge using the inputs present at that edge. The model's expected way_en, flush_req and empty are compared with the design on the next falling edge. Directed checks count the edges before they sample the residency boundary (still zero after edge R+I-1, one way after edge R+I) and the masks after each acknowledge.

// File: rtl/way_sizer.sv
module way_sizer #(
  parameter int NWAYS = 16,
  parameter int RESW  = 16,
  parameter int IVLW  = 8,
  localparam int CW   = $clog2(NWAYS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shrink_req,
  input  logic             wake,
  input  logic             deep_state,
  input  logic [CW-1:0]    step_ways,
  input  logic [RESW-1:0]  resid_cycles,
  input  logic [IVLW-1:0]  grow_ivl,
  input  logic             flush_done,
  output logic [NWAYS-1:0] way_en,
  output logic [NWAYS-1:0] flush_req,
  output logic             empty
);

  logic            busy, wk, grow_tick;
  logic [CW-1:0]   cnt, n_q, n_eff, lo, step_sat;
  logic [RESW-1:0] res;
  logic [IVLW-1:0] g, ivl;

  assign step_sat  = (step_ways == '0) ? CW'(1) :
                     (step_ways > CW'(NWAYS)) ? CW'(NWAYS) : step_ways;
  assign n_eff     = (n_q < cnt) ? n_q : cnt;
  assign lo        = cnt - n_eff;
  assign ivl       = (grow_ivl == '0) ? IVLW'(1) : grow_ivl;
  assign grow_tick = ({1'b0, g} + 1'b1) >= {1'b0, ivl};
  assign empty     = (cnt == '0);

  for (genvar i = 0; i < NWAYS; i++) begin : g_way
    assign way_en[i]    = CW'(i) < cnt;
    assign flush_req[i] = busy && (CW'(i) >= lo) && (CW'(i) < cnt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      wk   <= 1'b0;
      cnt  <= CW'(NWAYS);
      n_q  <= CW'(1);
      res  <= '0;
      g    <= '0;
    end else if (busy) begin
      res <= '0;
      g   <= '0;
      wk  <= wk | wake;
      if (flush_done) begin
        cnt <= lo;
        if (lo == '0 || wk || wake) busy <= 1'b0;
      end
    end else if (shrink_req && cnt != '0) begin
      busy <= 1'b1;
      n_q  <= step_sat;
      wk   <= 1'b0;
      res  <= '0;
      g    <= '0;
    end else if (deep_state) begin
      res <= '0;
      g   <= '0;
    end else if (res < resid_cycles) begin
      res <= res + 1'b1;
      g   <= '0;
    end else if (cnt < CW'(NWAYS)) begin
      if (grow_tick) begin
        cnt <= cnt + 1'b1;
        g   <= '0;
      end else begin
        g <= g + 1'b1;
      end
    end else begin
      g <= '0;
    end
  end

  p_flush_within_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req & ~way_en) == '0);

  p_hold_until_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !flush_done) |=> (cnt == $past(cnt)));

  p_empty_settled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (!busy && flush_req == '0));

  p_no_grow_deep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    deep_state |=> (cnt <= $past(cnt)));

  p_grow_by_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (int'(cnt) <= int'($past(cnt)) + 1));

  p_empty_shrink_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && empty && shrink_req) |=> !busy);

endmodule

// File: tb/way_sizer_tb_top.sv
module way_sizer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shrink_req = 1'b0, wake = 1'b0, deep_state = 1'b0, flush_done = 1'b0;
  logic [4:0]  step_ways = 5'd1;
  logic [15:0] resid_cycles = 16'd0;
  logic [7:0]  grow_ivl = 8'd1;
  logic [15:0] way_en, flush_req;
  logic        empty;

  always #2 clk = ~clk;

  way_sizer dut_i (
    .clk(clk), .rst_n(rst_n), .shrink_req(shrink_req), .wake(wake),
    .deep_state(deep_state), .step_ways(step_ways), .resid_cycles(resid_cycles),
    .grow_ivl(grow_ivl), .flush_done(flush_done), .way_en(way_en),
    .flush_req(flush_req), .empty(empty)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  // behavioural reference
  int m_cnt, m_n, m_res, m_g;
  bit m_busy, m_wk, chk_en = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 16; m_n = 1; m_res = 0; m_g = 0; m_busy = 0; m_wk = 0;
      chk_en = 1'b1;
    end else if (m_busy) begin
      int take;
      take = (m_n < m_cnt) ? m_n : m_cnt;
      m_res = 0; m_g = 0;
      if (flush_done) begin
        m_cnt = m_cnt - take;
        if (m_cnt == 0 || m_wk || wake) m_busy = 0;
      end
      m_wk = m_wk | wake;
    end else if (shrink_req && m_cnt > 0) begin
      m_busy = 1; m_wk = 0; m_res = 0; m_g = 0;
      m_n = (step_ways == 0) ? 1 : (step_ways > 16 ? 16 : int'(step_ways));
    end else if (deep_state) begin
      m_res = 0; m_g = 0;
    end else if (m_res < int'(resid_cycles)) begin
      m_res++; m_g = 0;
    end else if (m_cnt < 16) begin
      int gap;
      gap = (grow_ivl == 0) ? 1 : int'(grow_ivl);
      m_g++;
      if (m_g >= gap) begin m_cnt++; m_g = 0; end
    end else begin
      m_g = 0;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en && rst_n && !done) begin
      int take;
      logic [31:0] e_en, e_fl;
      take = (m_n < m_cnt) ? m_n : m_cnt;
      e_en = (32'd1 << m_cnt) - 1;
      e_fl = m_busy ? ((32'd1 << m_cnt) - (32'd1 << (m_cnt - take))) : 32'd0;
      chk("R5 model way_en", {16'd0, way_en}, e_en);
      chk("R2 model flush_req", {16'd0, flush_req}, e_fl);
      chk("R4 model empty", {31'd0, empty}, {31'd0, m_cnt == 0});
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  task automatic ack(int gap);
    repeat (gap) @(negedge clk);
    flush_done = 1'b1;
    @(negedge clk);
    flush_done = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset way_en", {16'd0, way_en}, 32'h0000FFFF);
    chk("R1 reset flush_req", {16'd0, flush_req}, 32'd0);
    chk("R1 reset empty", {31'd0, empty}, 32'd0);

    // step of 4, step input changed after start
    deep_state = 1'b1; step_ways = 5'd4; shrink_req = 1'b1;
    @(negedge clk);
    shrink_req = 1'b0; step_ways = 5'd1;
    chk("R2 first step mask", {16'd0, flush_req}, 32'h0000F000);
    ack(2);
    chk("R2 ways off after ack", {16'd0, way_en}, 32'h00000FFF);
    chk("R3 step held after change", {16'd0, flush_req}, 32'h00000F00);
    ack(1);
    ack(0);
    chk("R4 not empty mid shrink", {31'd0, empty}, 32'd0);
    ack(3);
    chk("R4 empty after last step", {31'd0, empty}, 32'd1);
    chk("R4 no ways", {16'd0, way_en}, 32'd0);

    // ignored stimuli
    shrink_req = 1'b1;
    @(negedge clk);
    shrink_req = 1'b0;
    chk("R8 shrink when empty", {16'd0, flush_req}, 32'd0);
    flush_done = 1'b1;
    @(negedge clk);
    flush_done = 1'b0;
    @(negedge clk);
    chk("R8 stray ack", {16'd0, way_en}, 32'd0);
    chk("R8 stray ack empty", {31'd0, empty}, 32'd1);

    // residency with an interruption, then regrowth
    resid_cycles = 16'd10; grow_ivl = 8'd3;
    deep_state = 1'b0;
    repeat (5) @(negedge clk);
    deep_state = 1'b1;
    @(negedge clk);
    deep_state = 1'b0;
    repeat (12) @(negedge clk);
    chk("R5 held before residency", {16'd0, way_en}, 32'd0);
    @(negedge clk);
    chk("R6 first way back", {16'd0, way_en}, 32'h00000001);
    repeat (3) @(negedge clk);
    chk("R6 second way back", {16'd0, way_en}, 32'h00000003);
    repeat (60) @(negedge clk);
    chk("R6 all ways back", {16'd0, way_en}, 32'h0000FFFF);

    // zero step, wake, clamp
    deep_state = 1'b1; step_ways = 5'd0; shrink_req = 1'b1;
    @(negedge clk);
    shrink_req = 1'b0;
    chk("R3 zero step as one", {16'd0, flush_req}, 32'h00008000);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    ack(1);
    chk("R7 stop after wake", {16'd0, way_en}, 32'h00007FFF);
    chk("R7 no flush after wake", {16'd0, flush_req}, 32'd0);
    repeat (4) @(negedge clk);
    chk("R7 mask kept", {16'd0, way_en}, 32'h00007FFF);
    step_ways = 5'd20; shrink_req = 1'b1;
    @(negedge clk);
    shrink_req = 1'b0;
    chk("R3 oversize clamped", {16'd0, flush_req}, 32'h00007FFF);
    ack(0);
    chk("R4 empty after clamp", {31'd0, empty}, 32'd1);

    // fast regrowth then mixed traffic
    resid_cycles = 16'd0; grow_ivl = 8'd0; deep_state = 1'b0;
    repeat (20) @(negedge clk);
    chk("R6 zero interval", {16'd0, way_en}, 32'h0000FFFF);
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      shrink_req = (r[3:0] == 4'd0);
      wake       = (r[7:4] == 4'd0);
      flush_done = (r[9:8] == 2'd0);
      if (r[14:10] == 5'd0) deep_state = ~deep_state;
      step_ways  = r[19:15];
      if (r[23:20] == 4'd0) resid_cycles = {13'd0, r[26:24]};
      if (r[30:27] == 4'd0) grow_ivl = {6'd0, r[25:24]};
      @(negedge clk);
    end
    shrink_req = 1'b0; wake = 1'b0; flush_done = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule